// File: doc/BRIEF.md
# Operand Forwarding Control Unit

This block generates the select signals for the bypass multiplexers of a five-stage in-order pipeline. The instruction about to leave decode can consume up to three register operands: two ALU sources and a separate store-data operand. The block compares each source register number against the destination numbers of the two older instructions, which sit in execute and memory. It then registers a select per operand. When the consumer enters execute, that select tells the datapath whether to take the latched register-file value, the execute/memory latch result, or the memory/write-back latch result.

A load does not have its data until the end of the memory stage. A consumer directly behind a load therefore cannot be served by forwarding alone. For this load-use case the block raises a combinational stall request in the same cycle. Decode is held for one cycle and a bubble enters execute. On the retry, the load has moved on and its value is taken from the memory/write-back latch. Producers that are ordinary ALU operations never cause a stall. The selects are decided per operand, so a store can have its address base and its data forwarded from different producers.

Top module: `fwd_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after reset, every select is 00 and stall is 0 for all-zero inputs.
- R2: If a used source equals the destination of a writing producer in execute, that operand's select is 10 (execute/memory latch) in the cycle after, unless a stall is raised.
- R3: If a used source matches only a writing producer in memory, its select is 01 (memory/write-back latch) in the cycle after.
- R4: If a source matches writing producers in both execute and memory, the select is 10, because the younger producer wins.
- R5: Source register 0 is never forwarded: its select is 00 and it never raises stall.
- R6: A producer whose write enable is low is ignored, both for the selects and for the stall.
- R7: An operand whose use flag is low gets select 00 and never raises stall.
- R8: Stall is 1 in the same cycle, with no clock delay, when a used nonzero source equals the destination of a writing load in execute.
- R9: In the cycle after a stall, all three selects are 00, because that cycle is the bubble.
- R10: A writing non-load producer in execute never raises stall, even when it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | REG_W | Decode-stage ALU source A register number |
| id_src_b | input | REG_W | Decode-stage ALU source B register number |
| id_src_st | input | REG_W | Decode-stage store-data register number |
| id_use_a | input | 1 | Source A is read |
| id_use_b | input | 1 | Source B is read |
| id_use_st | input | 1 | Store data is read |
| ex_rd | input | REG_W | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| sel_a | output | 2 | Bypass select for operand A (00 file, 10 exec/mem, 01 mem/wb) |
| sel_b | output | 2 | Bypass select for operand B |
| sel_st | output | 2 | Bypass select for store data |
| stall | output | 1 | Load-use stall request for decode |

## Verification
A wrong comparison or priority shows up at the ports one clock after the decode inputs are presented. At that point a select names the wrong latch, or the illegal code 11 appears. A bad load-use decision shows up at once on stall, because stall is combinational. It shows up again one cycle later, when the bubble does not carry all-zero selects. The sweep drives every combination of source, destinations, enables and load flag for a three-bit register space. An error in any single comparator therefore appears within one cycle of the first input that exercises it.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  localparam int NUM_OPS = 3;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_pick.sv
`timescale 1ns/1ps
module fwd_operand_pick
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output fwd_sel_e         sel_nxt,
  output logic             hit_ex
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic live;
  logic hit_mem;

  assign live    = used && (src != ZERO_REG);
  assign hit_ex  = live && ex_we  && (ex_rd  == src);
  assign hit_mem = live && mem_we && (mem_rd == src);

  // younger producer (execute) takes precedence over the older one
  always_comb begin
    if (hit_ex)       sel_nxt = SEL_EXMEM;
    else if (hit_mem) sel_nxt = SEL_MEMWB;
    else              sel_nxt = SEL_RF;
  end

  // R4: when both producers match, the memory/write-back path is not chosen
  always_comb begin
    if (hit_ex && hit_mem) begin
      p_prio_young_r4: assert (sel_nxt == SEL_EXMEM);
    end
  end
endmodule

// File: rtl/fwd_loaduse.sv
`timescale 1ns/1ps
module fwd_loaduse
  import fwd_pkg::*;
#(
  parameter int N = NUM_OPS
) (
  input  logic [N-1:0] hit_ex,
  input  logic         ex_is_load,
  output logic         stall
);
  assign stall = ex_is_load && (|hit_ex);
endmodule

// File: rtl/fwd_ctrl.sv
`timescale 1ns/1ps
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] id_src_st,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic             id_use_st,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [1:0]       sel_st,
  output logic             stall
);
  logic [REG_W-1:0] src_v [NUM_OPS];
  logic [NUM_OPS-1:0] use_v;
  logic [NUM_OPS-1:0] hit_ex_v;
  fwd_sel_e nxt_v [NUM_OPS];
  fwd_sel_e sel_q [NUM_OPS];

  assign src_v[0] = id_src_a;
  assign src_v[1] = id_src_b;
  assign src_v[2] = id_src_st;
  assign use_v    = {id_use_st, id_use_b, id_use_a};

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_op
      fwd_operand_pick #(.REG_W(REG_W)) u_pick (
        .src     (src_v[g]),
        .used    (use_v[g]),
        .ex_rd   (ex_rd),
        .ex_we   (ex_we),
        .mem_rd  (mem_rd),
        .mem_we  (mem_we),
        .sel_nxt (nxt_v[g]),
        .hit_ex  (hit_ex_v[g])
      );

      // the consumer moves to execute next cycle; a stall sends a bubble instead
      always_ff @(posedge clk) begin
        if (rst || stall) sel_q[g] <= SEL_RF;
        else              sel_q[g] <= nxt_v[g];
      end

      p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
        sel_q[g] != fwd_sel_e'(2'b11));

      p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
        (use_v[g] && src_v[g] == '0) |=> (sel_q[g] == SEL_RF));

      p_unused_r7: assert property (@(posedge clk) disable iff (rst)
        !use_v[g] |=> (sel_q[g] == SEL_RF));
    end
  endgenerate

  fwd_loaduse #(.N(NUM_OPS)) u_lu (
    .hit_ex     (hit_ex_v),
    .ex_is_load (ex_is_load),
    .stall      (stall)
  );

  assign sel_a  = sel_q[0];
  assign sel_b  = sel_q[1];
  assign sel_st = sel_q[2];

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_a == 2'b00 && sel_b == 2'b00 && sel_st == 2'b00));

  p_stall_needs_load_r8: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_is_load && ex_we && ex_rd != '0));

  p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> (sel_a == 2'b00 && sel_b == 2'b00 && sel_st == 2'b00));

  p_alu_nostall_r10: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load |-> !stall);
endmodule

// File: tb/fwd_ctrl_test.sv
`timescale 1ns/1ps
module fwd_ctrl_test;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] sa = '0, sb = '0, ss = '0, erd = '0, mrd = '0;
  logic ua = 1'b0, ub = 1'b0, us = 1'b0, ewe = 1'b0, eld = 1'b0, mwe = 1'b0;
  logic [1:0] sel_a, sel_b, sel_st;
  logic stall;

  int checks = 0;
  int fails = 0;
  logic [1:0] exp_q [3];
  string tag_q [3];

  always #2.5 clk = ~clk;

  fwd_ctrl #(.REG_W(W)) uut (
    .clk(clk), .rst(rst),
    .id_src_a(sa), .id_src_b(sb), .id_src_st(ss),
    .id_use_a(ua), .id_use_b(ub), .id_use_st(us),
    .ex_rd(erd), .ex_we(ewe), .ex_is_load(eld),
    .mem_rd(mrd), .mem_we(mwe),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st), .stall(stall)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model_sel(input logic [W-1:0] s, input logic u);
    if (!u || s == 0) return 2'b00;
    if (ewe && erd == s) return 2'b10;
    if (mwe && mrd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic model_hit(input logic [W-1:0] s, input logic u);
    return u && s != 0 && ewe && eld && erd == s;
  endfunction

  function automatic string sel_tag(input logic [W-1:0] s, input logic u);
    if (!u) return "R7";
    if (s == 0) return "R5";
    if (ewe && erd == s && mwe && mrd == s) return "R4";
    if (ewe && erd == s) return "R2";
    if (!ewe && erd == s) return "R6";
    return "R3";
  endfunction

  task automatic step(input logic [W-1:0] a, b, st, input logic u_a, u_b, u_s,
                      input logic [W-1:0] e, input logic e_we, e_ld,
                      input logic [W-1:0] m, input logic m_we);
    logic exp_st;
    string stag;
    @(negedge clk);
    chk(tag_q[0], sel_a,  exp_q[0], "sel_a");
    chk(tag_q[1], sel_b,  exp_q[1], "sel_b");
    chk(tag_q[2], sel_st, exp_q[2], "sel_st");
    sa = a; sb = b; ss = st; ua = u_a; ub = u_b; us = u_s;
    erd = e; ewe = e_we; eld = e_ld; mrd = m; mwe = m_we;
    #1;
    exp_st = model_hit(sa, ua) || model_hit(sb, ub) || model_hit(ss, us);
    if (exp_st) stag = "R8";
    else if (ewe && !eld) stag = "R10";
    else if (!ewe) stag = "R6";
    else stag = "R7";
    chk(stag, stall, exp_st, "stall");
    if (exp_st) begin
      for (int k = 0; k < 3; k++) begin exp_q[k] = 2'b00; tag_q[k] = "R9"; end
    end else begin
      exp_q[0] = model_sel(sa, ua); tag_q[0] = sel_tag(sa, ua);
      exp_q[1] = model_sel(sb, ub); tag_q[1] = sel_tag(sb, ub);
      exp_q[2] = model_sel(ss, us); tag_q[2] = sel_tag(ss, us);
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin exp_q[k] = 2'b00; tag_q[k] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", sel_a, 0, "reset sel_a");
    chk("R1", sel_b, 0, "reset sel_b");
    chk("R1", sel_st, 0, "reset sel_st");
    chk("R1", stall, 0, "reset stall");
    rst = 1'b0;
    // ALU result feeds next instruction: R2 forward, no stall (R10)
    step(3'd3, 3'd5, 3'd0, 1, 1, 0, 3'd3, 1, 0, 3'd0, 0);
    // store data produced just ahead: forwarded on store operand only
    step(3'd4, 3'd0, 3'd3, 1, 0, 1, 3'd3, 1, 0, 3'd2, 1);
    // load then dependent use: stall, bubble, then memory/write-back path
    step(3'd4, 3'd3, 3'd0, 1, 1, 0, 3'd4, 1, 1, 3'd3, 1);
    step(3'd4, 3'd3, 3'd0, 1, 1, 0, 3'd0, 0, 0, 3'd4, 1);
    step(3'd0, 3'd0, 3'd0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 0);
    // near-exhaustive sweep
    for (int a = 0; a < 8; a++)
      for (int e = 0; e < 8; e++)
        for (int m = 0; m < 8; m++)
          for (int w = 0; w < 4; w++)
            for (int l = 0; l < 2; l++)
              for (int u = 0; u < 2; u++)
                step(W'(a), W'(m), W'(e ^ u), u[0], ~u[0] | w[0], l[0] ^ w[1],
                     W'(e), w[0], l[0], W'(m), w[1]);
    step(3'd0, 3'd0, 3'd0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule